// File: doc/BRIEF.md
# Burst Read Data Controller

This block runs the data side of a processor bus read. After the data bus is granted it accepts either one doubleword or a four-beat burst. That covers a 32-byte cache line on a 64-bit bus with one parity bit per byte lane. It counts the acknowledged beats, checks lane parity on each beat, and hands each surviving doubleword, tagged with its beat index, to the cache fill path. A completion pulse marks the final beat.

Three data-phase modes set how a beat is qualified:

- **Normal:** each acknowledged beat waits one cycle in a hold register, where the data-retry input can cancel it. A cancelled beat is sent again.
- **Streaming:** only the final beat of a tenure can be cancelled.
- **Fast mode:** the hold cycle is skipped, so data arrives one bus cycle sooner. Data retry is ignored, both for beats and for qualifying the grant.

The mode and the transfer size are sampled only when a tenure starts.

Top module: `rbc_top`

## Requirements
- R1: While reset is asserted and after its release, `fill_valid_o`, `done_o`, `busy_o` and `perr_o` are 0.
- R2: A tenure starts only when the block is idle and a grant is qualified. In normal (mode 2'b00) and streaming (2'b01), a qualified grant is `dbg_i` high with `drtry_i` low. In fast mode (2'b10), `dbg_i` alone qualifies. `busy_o` is high from the next cycle. Mode 2'b11 behaves as normal.
- R3: `burst_i`=1 means 4 beats and `burst_i`=0 means 1 beat. Forwarded beats carry indices 0 upward on `fill_beat_o`. An acknowledge while idle, or after all beats of the tenure are captured, produces no output.
- R4: In normal and streaming modes, a beat acknowledged at clock edge n appears on `fill_valid_o`/`fill_data_o` after edge n+1.
- R5: In normal mode, `drtry_i` high in the cycle after a beat's capture discards that beat. An acknowledge in that same cycle is ignored. The next acknowledge carries the same beat index.
- R6: In fast mode, a beat acknowledged at edge n appears after edge n, and `drtry_i` never discards a beat.
- R7: In streaming mode, `drtry_i` discards only the final beat of the tenure. On earlier beats it has no effect.
- R8: `done_o` pulses for one cycle together with the final beat's `fill_valid_o`, and `busy_o` is low in that same cycle.
- R9: Parity is even per lane: `par_i[k]` must equal the XOR of `data_i[8k+7:8k]`. A mismatch on a captured beat sets `perr_o`, which stays high until reset. `perr_beat_o` holds the index of the first failing beat.
- R10: Changing `mode_i` during a tenure has no effect on that tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_i | input | 1 | Data bus grant |
| ta_i | input | 1 | Transfer acknowledge for one beat |
| drtry_i | input | 1 | Data retry |
| mode_i | input | 2 | Data-phase mode: 00 normal, 01 streaming, 10 fast |
| burst_i | input | 1 | 1 = four-beat burst, 0 = single beat |
| data_i | input | 64 | Read data bus |
| par_i | input | 8 | Per-lane even parity |
| fill_valid_o | output | 1 | Forwarded doubleword valid |
| fill_data_o | output | 64 | Forwarded doubleword |
| fill_beat_o | output | 2 | Beat index of forwarded doubleword |
| done_o | output | 1 | Tenure complete pulse |
| busy_o | output | 1 | Data tenure in progress |
| perr_o | output | 1 | Sticky parity error |
| perr_beat_o | output | 2 | Index of first failing beat |

## Verification
A beat acknowledged at edge n is due after edge n+1 in normal and streaming modes, and after edge n in fast mode. `done_o` is due in the same cycle as the final beat, and `busy_o` in the cycle after the grant.

The driver task stamps every expected doubleword with the cycle number in which it must appear. The monitor compares its own cycle counter against that stamp at each falling edge, so a beat that arrives early, late, or is never discarded fails.

Beats the design must drop are never queued. A stray output with an empty queue is therefore reported as well.

// File: rtl/rbc_pkg.sv
package rbc_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL  = 2'b00,
    MODE_STREAM  = 2'b01,
    MODE_FAST    = 2'b10,
    MODE_RSVD    = 2'b11
  } dmode_e;

  // Even parity for one byte lane: the bit that makes the lane's ones even.
  function automatic logic lane_even_par(input logic [7:0] b);
    return ^b;
  endfunction

  // Beats in a tenure for a given size bit.
  function automatic int unsigned tenure_beats(input logic burst, input int unsigned burst_len);
    return burst ? burst_len : 1;
  endfunction

  // Grant qualification: fast mode does not consult the retry line.
  function automatic logic grant_ok(input logic dbg, input logic drtry, input dmode_e m);
    return dbg && ((m == MODE_FAST) || !drtry);
  endfunction

endpackage

// File: rtl/rbc_parity_chk.sv
module rbc_parity_chk #(
  parameter int LANES = 8
) (
  input  logic [LANES*8-1:0] data,
  input  logic [LANES-1:0]   par,
  output logic [LANES-1:0]   lane_bad,
  output logic               any_bad
);
  import rbc_pkg::*;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_bad[k] = lane_even_par(data[k*8 +: 8]) ^ par[k];
  end

  assign any_bad = |lane_bad;

endmodule

// File: rtl/rbc_beat_ctr.sv
module rbc_beat_ctr #(
  parameter int MAX_BEATS = 4,
  localparam int CW = $clog2(MAX_BEATS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  input  logic          dec,
  input  logic [CW-1:0] total,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          at_last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (inc)   count <= count + 1'b1;
    else if (dec)   count <= count - 1'b1;
  end

  assign full    = (count == total);
  assign at_last = ((count + 1'b1) == total);

  // R3: captured beats never exceed the tenure length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= total);

  // R5: a rewind only happens when a beat is outstanding
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (count != '0));

  // R5: capture and rewind never coincide
  p_inc_dec_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));

endmodule

// File: rtl/rbc_top.sv
module rbc_top #(
  parameter int DATA_W    = 64,
  parameter int BURST_LEN = 4,
  localparam int LANES = DATA_W / 8,
  localparam int IDX_W = $clog2(BURST_LEN),
  localparam int CW    = $clog2(BURST_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_i,
  input  logic              ta_i,
  input  logic              drtry_i,
  input  logic [1:0]        mode_i,
  input  logic              burst_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [LANES-1:0]  par_i,
  output logic              fill_valid_o,
  output logic [DATA_W-1:0] fill_data_o,
  output logic [IDX_W-1:0]  fill_beat_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              perr_o,
  output logic [IDX_W-1:0]  perr_beat_o
);
  import rbc_pkg::*;

  // Tenure state
  logic   busy_q;
  dmode_e mode_q;
  logic   burst_q;

  // Hold stage (normal and streaming modes)
  logic              hold_v;
  logic [DATA_W-1:0] hold_data;
  logic [IDX_W-1:0]  hold_idx;
  logic              hold_last;

  // Named internal events
  logic              start_ev;
  logic              capture_ev;
  logic              retry_ev;
  logic              fast_m;
  logic              stream_m;
  logic [CW-1:0]     total;
  logic [CW-1:0]     cnt;
  logic              cnt_full;
  logic              cnt_last;
  logic              par_bad;
  logic [LANES-1:0]  lane_bad;
  logic              fwd_v;
  logic [DATA_W-1:0] fwd_data;
  logic [IDX_W-1:0]  fwd_idx;
  logic              fwd_last;

  assign fast_m   = (mode_q == MODE_FAST);
  assign stream_m = (mode_q == MODE_STREAM);
  assign total    = CW'(tenure_beats(burst_q, BURST_LEN));

  assign start_ev   = !busy_q && grant_ok(dbg_i, drtry_i, dmode_e'(mode_i));
  assign retry_ev   = hold_v && drtry_i && !fast_m && (!stream_m || hold_last);
  assign capture_ev = busy_q && ta_i && !retry_ev && !cnt_full;

  rbc_beat_ctr #(.MAX_BEATS(BURST_LEN)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_ev),
    .inc     (capture_ev),
    .dec     (retry_ev),
    .total   (total),
    .count   (cnt),
    .full    (cnt_full),
    .at_last (cnt_last)
  );

  rbc_parity_chk #(.LANES(LANES)) u_par (
    .data     (data_i),
    .par      (par_i),
    .lane_bad (lane_bad),
    .any_bad  (par_bad)
  );

  // Forwarding source: straight from the bus in fast mode, else from hold.
  always_comb begin
    if (fast_m) begin
      fwd_v    = capture_ev;
      fwd_data = data_i;
      fwd_idx  = cnt[IDX_W-1:0];
      fwd_last = cnt_last;
    end else begin
      fwd_v    = hold_v && !retry_ev;
      fwd_data = hold_data;
      fwd_idx  = hold_idx;
      fwd_last = hold_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      mode_q  <= MODE_NORMAL;
      burst_q <= 1'b0;
    end else if (start_ev) begin
      busy_q  <= 1'b1;
      mode_q  <= dmode_e'(mode_i);
      burst_q <= burst_i;
    end else if (fwd_v && fwd_last) begin
      busy_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v    <= 1'b0;
      hold_data <= '0;
      hold_idx  <= '0;
      hold_last <= 1'b0;
    end else begin
      hold_v <= capture_ev && !fast_m;
      if (capture_ev) begin
        hold_data <= data_i;
        hold_idx  <= cnt[IDX_W-1:0];
        hold_last <= cnt_last;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_valid_o <= 1'b0;
      fill_data_o  <= '0;
      fill_beat_o  <= '0;
      done_o       <= 1'b0;
    end else begin
      fill_valid_o <= fwd_v;
      done_o       <= fwd_v && fwd_last;
      if (fwd_v) begin
        fill_data_o <= fwd_data;
        fill_beat_o <= fwd_idx;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perr_o      <= 1'b0;
      perr_beat_o <= '0;
    end else if (capture_ev && par_bad && !perr_o) begin
      perr_o      <= 1'b1;
      perr_beat_o <= cnt[IDX_W-1:0];
    end
  end

  assign busy_o = busy_q;

  // R8: completion only accompanies a forwarded beat
  p_done_with_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> fill_valid_o);

  // R8: the tenure has ended when completion is shown
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10: the latched mode cannot move while a tenure continues
  p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(mode_q));

  // R9: parity error flag is sticky
  p_perr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    perr_o |=> perr_o);

  // R6: fast mode forwards on the edge after acknowledge
  p_fast_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_ev && fast_m) |=> fill_valid_o);

  // R5: a retried beat is never forwarded
  p_retry_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    retry_ev |=> !fill_valid_o);

  // R3: no output emerges from an idle block
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |=> !fill_valid_o);

endmodule

// File: tb/tb_rbc_top.sv
module tb_rbc_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbg_i, ta_i, drtry_i, burst_i;
  logic [1:0]  mode_i;
  logic [63:0] data_i;
  logic [7:0]  par_i;
  logic        fill_valid_o, done_o, busy_o, perr_o;
  logic [63:0] fill_data_o;
  logic [1:0]  fill_beat_o, perr_beat_o;

  rbc_top dut (
    .clk(clk), .rst_n(rst_n), .dbg_i(dbg_i), .ta_i(ta_i), .drtry_i(drtry_i),
    .mode_i(mode_i), .burst_i(burst_i), .data_i(data_i), .par_i(par_i),
    .fill_valid_o(fill_valid_o), .fill_data_o(fill_data_o), .fill_beat_o(fill_beat_o),
    .done_o(done_o), .busy_o(busy_o), .perr_o(perr_o), .perr_beat_o(perr_beat_o)
  );

  always #10 clk = ~clk; // 50 MHz

  typedef struct packed {
    logic [63:0] d;
    logic [1:0]  idx;
    logic        last;
    int          due;
    int          req;
  } exp_t;

  exp_t sb[$];
  exp_t e;
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  int   cur_lat = 2;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bench's own even-parity: count ones per lane.
  function automatic logic [7:0] mk_par(input logic [63:0] d);
    logic [7:0] p;
    for (int k = 0; k < 8; k++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += int'(d[k*8+b]);
      p[k] = (ones % 2) == 1;
    end
    return p;
  endfunction

  // Monitor: pops scoreboard as the design forwards beats.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (fill_valid_o) begin
        if (sb.size() == 0) begin
          chk(0, "R3", "unexpected fill", fill_data_o, 64'h0);
        end else begin
          e = sb.pop_front();
          chk(fill_data_o == e.d, $sformatf("R%0d", e.req), "fill data", fill_data_o, e.d);
          chk(fill_beat_o == e.idx, $sformatf("R%0d", e.req), "beat index", 64'(fill_beat_o), 64'(e.idx));
          chk(cyc == e.due, $sformatf("R%0d", e.req), "arrival cycle", 64'(cyc), 64'(e.due));
          chk(done_o == e.last, "R8", "done with last", 64'(done_o), 64'(e.last));
        end
      end else if (done_o) begin
        chk(0, "R8", "done without fill", 64'(done_o), 64'h0);
      end
    end
  end

  task automatic grant(input logic [1:0] m, input logic b, input logic rt);
    dbg_i = 1'b1; mode_i = m; burst_i = b; drtry_i = rt;
    @(negedge clk);
    dbg_i = 1'b0; drtry_i = 1'b0;
  endtask

  // One beat: ta for a cycle; optional gap cycle carrying drtry.
  task automatic beat(input logic [63:0] d, input logic [1:0] idx, input logic last,
                      input bit keep, input bit rt, input bit gap, input bit badpar,
                      input int req);
    exp_t x;
    ta_i = 1'b1; data_i = d; par_i = mk_par(d) ^ {7'b0, badpar};
    if (keep) begin
      x.d = d; x.idx = idx; x.last = last; x.due = cyc + cur_lat; x.req = req;
      sb.push_back(x);
    end
    @(negedge clk);
    if (gap) begin
      ta_i = 1'b0; drtry_i = rt;
      @(negedge clk);
      drtry_i = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    ta_i = 1'b0; dbg_i = 1'b0; drtry_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dbg_i = 0; ta_i = 0; drtry_i = 0; mode_i = 2'b00; burst_i = 0;
    data_i = '0; par_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!fill_valid_o && !done_o && !busy_o && !perr_o, "R1", "reset outputs",
        {60'h0, fill_valid_o, done_o, busy_o, perr_o}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !fill_valid_o, "R1", "after release", {62'h0, busy_o, fill_valid_o}, 64'h0);

    // R4 normal burst with gaps
    cur_lat = 2;
    grant(2'b00, 1'b1, 1'b0);
    chk(busy_o, "R2", "busy after grant", 64'(busy_o), 64'h1);
    beat(64'h1111_0000_0000_0001, 2'd0, 0, 1, 0, 1, 0, 4);
    beat(64'h1111_0000_0000_0002, 2'd1, 0, 1, 0, 1, 0, 4);
    beat(64'h1111_0000_0000_0003, 2'd2, 0, 1, 0, 1, 0, 4);
    beat(64'h1111_0000_0000_0004, 2'd3, 1, 1, 0, 1, 0, 4);
    idle(2);
    chk(!busy_o, "R8", "idle after burst", 64'(busy_o), 64'h0);

    // R3 single beat
    grant(2'b00, 1'b0, 1'b0);
    beat(64'hABCD_0000_1234_5678, 2'd0, 1, 1, 0, 1, 0, 3);
    idle(2);

    // R2 grant blocked by retry in normal mode; R3 ta while idle ignored
    grant(2'b00, 1'b1, 1'b1);
    chk(!busy_o, "R2", "retry blocks grant", 64'(busy_o), 64'h0);
    beat(64'hDEAD_BEEF_0000_0000, 2'd0, 0, 0, 0, 1, 0, 3);
    chk(!fill_valid_o, "R3", "idle ack ignored", 64'(fill_valid_o), 64'h0);
    idle(1);

    // R5 retry in normal mode: beat 1 discarded and resent
    grant(2'b00, 1'b1, 1'b0);
    beat(64'h2222_0000_0000_0000, 2'd0, 0, 1, 0, 1, 0, 5);
    beat(64'h2222_BAD0_0000_0001, 2'd1, 0, 0, 1, 1, 0, 5);
    beat(64'h2222_0000_0000_0001, 2'd1, 0, 1, 0, 1, 0, 5);
    beat(64'h2222_0000_0000_0002, 2'd2, 0, 1, 0, 1, 0, 5);
    beat(64'h2222_0000_0000_0003, 2'd3, 1, 1, 0, 1, 0, 5);
    idle(2);

    // R6 fast mode: grant with retry high qualifies, retry ignored, one cycle sooner
    cur_lat = 1;
    grant(2'b10, 1'b1, 1'b1);
    chk(busy_o, "R6", "fast grant ignores retry", 64'(busy_o), 64'h1);
    beat(64'h3333_0000_0000_0000, 2'd0, 0, 1, 0, 1, 0, 6);
    beat(64'h3333_0000_0000_0001, 2'd1, 0, 1, 1, 1, 0, 6);
    beat(64'h3333_0000_0000_0002, 2'd2, 0, 1, 0, 0, 0, 6);
    beat(64'h3333_0000_0000_0003, 2'd3, 1, 1, 0, 0, 0, 6);
    idle(2);

    // R3 back-to-back normal burst, extra acknowledge past the count ignored
    cur_lat = 2;
    grant(2'b00, 1'b1, 1'b0);
    beat(64'h4444_0000_0000_0000, 2'd0, 0, 1, 0, 0, 0, 3);
    beat(64'h4444_0000_0000_0001, 2'd1, 0, 1, 0, 0, 0, 3);
    beat(64'h4444_0000_0000_0002, 2'd2, 0, 1, 0, 0, 0, 3);
    beat(64'h4444_0000_0000_0003, 2'd3, 1, 1, 0, 0, 0, 3);
    beat(64'h4444_FFFF_0000_0004, 2'd0, 0, 0, 0, 0, 0, 3);
    idle(3);

    // R7 streaming: retry ignored mid-burst, honoured on last beat
    grant(2'b01, 1'b1, 1'b0);
    beat(64'h5555_0000_0000_0000, 2'd0, 0, 1, 0, 1, 0, 7);
    beat(64'h5555_0000_0000_0001, 2'd1, 0, 1, 1, 1, 0, 7);
    beat(64'h5555_0000_0000_0002, 2'd2, 0, 1, 0, 1, 0, 7);
    beat(64'h5555_BAD0_0000_0003, 2'd3, 1, 0, 1, 1, 0, 7);
    beat(64'h5555_0000_0000_0003, 2'd3, 1, 1, 0, 1, 0, 7);
    idle(2);

    // R10 mode change mid-tenure: stays normal (retry honoured, latency 2)
    grant(2'b00, 1'b1, 1'b0);
    beat(64'h6666_0000_0000_0000, 2'd0, 0, 1, 0, 1, 0, 10);
    mode_i = 2'b10;
    beat(64'h6666_BAD0_0000_0001, 2'd1, 0, 0, 1, 1, 0, 10);
    beat(64'h6666_0000_0000_0001, 2'd1, 0, 1, 0, 1, 0, 10);
    beat(64'h6666_0000_0000_0002, 2'd2, 0, 1, 0, 1, 0, 10);
    beat(64'h6666_0000_0000_0003, 2'd3, 1, 1, 0, 1, 0, 10);
    mode_i = 2'b00;
    idle(2);

    // R9 parity error on beat 2, sticky and first index kept
    chk(!perr_o, "R9", "no error before", 64'(perr_o), 64'h0);
    grant(2'b00, 1'b1, 1'b0);
    beat(64'h7777_0000_0000_0000, 2'd0, 0, 1, 0, 1, 0, 9);
    beat(64'h7777_0000_0000_0001, 2'd1, 0, 1, 0, 1, 0, 9);
    beat(64'h7777_0000_0000_0002, 2'd2, 0, 1, 0, 1, 1, 9);
    beat(64'h7777_0000_0000_0003, 2'd3, 1, 1, 0, 1, 0, 9);
    idle(2);
    chk(perr_o, "R9", "error flag", 64'(perr_o), 64'h1);
    chk(perr_beat_o == 2'd2, "R9", "error beat", 64'(perr_beat_o), 64'h2);
    grant(2'b00, 1'b0, 1'b0);
    beat(64'h8888_0000_0000_0000, 2'd0, 1, 1, 0, 1, 1, 9);
    idle(2);
    chk(perr_o && perr_beat_o == 2'd2, "R9", "sticky first index",
        {61'h0, perr_o, perr_beat_o}, 64'h6);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!perr_o, "R1", "reset clears error", 64'(perr_o), 64'h0);
    rst_n = 1'b1;
    idle(2);

    chk(sb.size() == 0, "R3", "scoreboard drained", 64'(sb.size()), 64'h0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule